// File: doc/BRIEF.md
# Column-Major Array Element Address Generator

This unit turns a set of 1-based FORTRAN-style subscripts into the word address of one element of a two- or three-dimensional column-major array. A start pulse captures the array base address, the subscripts, the dimension ranges, the element size in words and a selector word. The unit then computes the linear element offset and scales it by the element size. It adds the result to the base, presents the 16-bit address on `addr` and raises `done` for one cycle. Operand fetch from memory and bounds checking belong to the surrounding logic.

Each product is formed by one shared shift-and-add multiplier that retires one multiplier bit per cycle. A small state machine schedules the multiplies. IDLE waits for `start`. On `start`, IDLE moves to LOAD, where the operands are captured and every subscript has one subtracted from it. LOAD moves to RUN_KD2 when the selector's least significant bit is 1 and to RUN_JD1 when it is 0. RUN_KD2 forms (k−1)·D2 and moves to RUN_JD1. RUN_JD1 multiplies the running sum by D1 and moves to RUN_ESZ. RUN_ESZ multiplies the complete offset by the element size and moves to RESULT, and on that same edge the address register is written. RESULT always moves on to FINISH, which drives `done`. FINISH always returns to IDLE. Every multiply state moves on only when the multiplier reports completion.

Top module: `array_addr_gen`

## Requirements
- R1: After reset, `addr` is 0 and `done` is 0.
- R2: One is subtracted from the first subscript before any other arithmetic. With i=1, j=1 (and k=1), the result equals the base address.
- R3: When `sel[0]` is 0, the offset is (i−1) + (j−1)·D1. The `sub_k` and `rng2` inputs do not affect the result.
- R4: When `sel[0]` is 1, the offset is (i−1) + ((k−1)·D2 + (j−1))·D1.
- R5: Bits 15..1 of `sel` have no effect on the result. Only bit 0 selects the mode.
- R6: `addr` = base + offset·`elem_size`, with all arithmetic taken modulo 2^16.
- R7: Zero or negative (two's complement) subscripts produce wrapped addresses with no error indication.
- R8: All operands are captured at `start`. Input changes after the start cycle do not alter the result.
- R9: `done` is a one-cycle pulse. It rises one cycle after `addr` takes the new value, and `addr` holds that value until the next result.
- R10: A `start` pulse that arrives while a computation is in progress is ignored. The running result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures operands and begins a computation when idle |
| base | input | 16 | Array base address |
| sub_i | input | 16 | First subscript (1-based) |
| sub_j | input | 16 | Second subscript (1-based) |
| sub_k | input | 16 | Third subscript (1-based, 3-D mode only) |
| rng1 | input | 16 | First dimension range D1 |
| rng2 | input | 16 | Second dimension range D2 (3-D mode only) |
| elem_size | input | 16 | Element size in words |
| sel | input | 16 | Selector word; bit 0 picks 3-D (1) or 2-D (0) |
| addr | output | 16 | Computed element address |
| done | output | 1 | One-cycle pulse after `addr` is updated |

## Verification
Unit subscripts isolate the decrement of the first subscript from the scaling. Small 2-D and 3-D cases with distinct ranges show whether D1 and D2 are applied to the right subscripts. The same operands are run with the upper selector bits set and bit 0 toggled, and with garbage on `sub_k` and `rng2` in 2-D mode, which shows that only bit 0 and only the 3-D operands in 3-D mode matter. Zero subscripts and large values force 16-bit wraparound. Inputs are scrambled after each start, and a second start is injected mid-run, to separate operand capture from live inputs. Seeded random operands in both modes cover the general arithmetic.

// File: rtl/aag_pkg.sv
package aag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN_KD2,
        ST_RUN_JD1,
        ST_RUN_ESZ,
        ST_RESULT,
        ST_FINISH
    } aag_state_e;

endpackage

// File: rtl/aag_opnd_reg.sv
module aag_opnd_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] base_in,
    input  logic [W-1:0] i_in,
    input  logic [W-1:0] j_in,
    input  logic [W-1:0] k_in,
    input  logic [W-1:0] r1_in,
    input  logic [W-1:0] r2_in,
    input  logic [W-1:0] esz_in,
    input  logic         mode_in,
    output logic [W-1:0] base_q,
    output logic [W-1:0] im1_q,
    output logic [W-1:0] jm1_q,
    output logic [W-1:0] km1_q,
    output logic [W-1:0] r1_q,
    output logic [W-1:0] r2_q,
    output logic [W-1:0] esz_q,
    output logic         use3d_q
);

    localparam logic [W-1:0] ONE = W'(1);

    // Subscripts are stored already reduced to 0-based form.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            im1_q   <= '0;
            jm1_q   <= '0;
            km1_q   <= '0;
            r1_q    <= '0;
            r2_q    <= '0;
            esz_q   <= '0;
            use3d_q <= 1'b0;
        end else if (load) begin
            base_q  <= base_in;
            im1_q   <= i_in - ONE;
            jm1_q   <= j_in - ONE;
            km1_q   <= k_in - ONE;
            r1_q    <= r1_in;
            r2_q    <= r2_in;
            esz_q   <= esz_in;
            use3d_q <= mode_in;
        end
    end

endmodule

// File: rtl/aag_seq_mul.sv
module aag_seq_mul #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] product,
    output logic         fin
);

    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] STEPS = CW'(W);
    localparam logic [CW-1:0] LAST  = CW'(1);

    logic [W-1:0]  mcand;
    logic [W-1:0]  mplier;
    logic [W-1:0]  acc;
    logic [CW-1:0] cnt;
    logic          busy;
    logic          fin_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
            fin_r  <= 1'b0;
        end else if (go) begin
            mcand  <= a;
            mplier <= b;
            acc    <= '0;
            cnt    <= STEPS;
            busy   <= 1'b1;
            fin_r  <= 1'b0;
        end else if (busy) begin
            acc    <= acc + (mplier[0] ? mcand : '0);
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt - LAST;
            if (cnt == LAST) begin
                busy  <= 1'b0;
                fin_r <= 1'b1;
            end
        end else begin
            fin_r <= 1'b0;
        end
    end

    assign product = acc;
    assign fin     = fin_r;

    // R6
    mul_fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

    // R6
    mul_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= STEPS);

endmodule

// File: rtl/array_addr_gen.sv
module array_addr_gen #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] base,
    input  logic [W-1:0] sub_i,
    input  logic [W-1:0] sub_j,
    input  logic [W-1:0] sub_k,
    input  logic [W-1:0] rng1,
    input  logic [W-1:0] rng2,
    input  logic [W-1:0] elem_size,
    input  logic [W-1:0] sel,
    output logic [W-1:0] addr,
    output logic         done
);
    import aag_pkg::*;

    aag_state_e state;
    aag_state_e state_nx;

    logic [W-1:0] base_q, im1_q, jm1_q, km1_q, r1_q, r2_q, esz_q;
    logic         use3d_q;
    logic         load;
    logic         mul_go;
    logic [W-1:0] mul_a;
    logic [W-1:0] mul_b;
    logic [W-1:0] mul_p;
    logic         mul_fin;
    logic [W-1:0] addr_q;
    logic         sel_hi_unused;

    assign sel_hi_unused = ^sel[W-1:1];

    aag_opnd_reg #(.W(W)) u_opnd (
        .clk(clk), .rst_n(rst_n), .load(load),
        .base_in(base), .i_in(sub_i), .j_in(sub_j), .k_in(sub_k),
        .r1_in(rng1), .r2_in(rng2), .esz_in(elem_size), .mode_in(sel[0]),
        .base_q(base_q), .im1_q(im1_q), .jm1_q(jm1_q), .km1_q(km1_q),
        .r1_q(r1_q), .r2_q(r2_q), .esz_q(esz_q), .use3d_q(use3d_q)
    );

    aag_seq_mul #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go),
        .a(mul_a), .b(mul_b), .product(mul_p), .fin(mul_fin)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_LOAD;
            ST_LOAD:    state_nx = use3d_q ? ST_RUN_KD2 : ST_RUN_JD1;
            ST_RUN_KD2: if (mul_fin) state_nx = ST_RUN_JD1;
            ST_RUN_JD1: if (mul_fin) state_nx = ST_RUN_ESZ;
            ST_RUN_ESZ: if (mul_fin) state_nx = ST_RESULT;
            ST_RESULT:  state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs: operand capture, multiplier launch and operand steering
    always_comb begin
        load   = 1'b0;
        mul_go = 1'b0;
        mul_a  = '0;
        mul_b  = '0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_LOAD: begin
                mul_go = 1'b1;
                mul_a  = use3d_q ? km1_q : jm1_q;
                mul_b  = use3d_q ? r2_q  : r1_q;
            end
            ST_RUN_KD2: begin
                mul_go = mul_fin;
                mul_a  = mul_p + jm1_q;
                mul_b  = r1_q;
            end
            ST_RUN_JD1: begin
                mul_go = mul_fin;
                mul_a  = mul_p + im1_q;
                mul_b  = esz_q;
            end
            ST_RUN_ESZ: ;
            ST_RESULT:  ;
            ST_FINISH:  done = 1'b1;
            default:    ;
        endcase
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (state == ST_RUN_ESZ && mul_fin)
            addr_q <= base_q + mul_p;
    end

    assign addr = addr_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr) |-> state == ST_RESULT);

    // R9
    done_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state) == ST_RESULT);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> state != ST_LOAD);

    // R3
    mode_2d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !use3d_q) |=> state == ST_RUN_JD1);

    // R4
    mode_3d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && use3d_q) |=> state == ST_RUN_KD2);

endmodule

// File: tb/sim_array_addr_gen.sv
`timescale 1ns/1ps
module sim_array_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base = '0, sub_i = '0, sub_j = '0, sub_k = '0;
    logic [15:0] rng1 = '0, rng2 = '0, elem_size = '0, sel = '0;
    logic [15:0] addr;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    array_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base),
        .sub_i(sub_i), .sub_j(sub_j), .sub_k(sub_k),
        .rng1(rng1), .rng2(rng2), .elem_size(elem_size), .sel(sel),
        .addr(addr), .done(done)
    );

    function automatic logic [15:0] exp_addr(
        input logic [15:0] b, input logic [15:0] i, input logic [15:0] j,
        input logic [15:0] k, input logic [15:0] d1, input logic [15:0] d2,
        input logic [15:0] es, input logic [15:0] s);
        logic [15:0] off;
        logic [15:0] inner;
        if (s[0]) begin
            inner = (k - 16'd1) * d2 + (j - 16'd1);
            off   = (i - 16'd1) + inner * d1;
        end else begin
            off   = (i - 16'd1) + (j - 16'd1) * d1;
        end
        return b + off * es;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(
        input logic [15:0] b, input logic [15:0] i, input logic [15:0] j,
        input logic [15:0] k, input logic [15:0] d1, input logic [15:0] d2,
        input logic [15:0] es, input logic [15:0] s,
        input string req, input bit disturb);
        logic [15:0] exp;
        logic [15:0] prev;
        int cyc;
        exp = exp_addr(b, i, j, k, d1, d2, es, s);
        @(negedge clk);
        base = b; sub_i = i; sub_j = j; sub_k = k;
        rng1 = d1; rng2 = d2; elem_size = es; sel = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble the inputs once they have been captured
        base = ~b; sub_i = i + 16'd3; sub_j = j ^ 16'h00F0; sub_k = k + 16'd7;
        rng1 = d1 + 16'd5; rng2 = ~d2; elem_size = es + 16'd1; sel = ~s;
        cyc = 0;
        prev = addr;
        while (!done && cyc < 400) begin
            prev = addr;
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 5) start = 1'b1;
            if (disturb && cyc == 6) start = 1'b0;
        end
        start = 1'b0;
        if (!done) begin
            checks++; errors++;
            $display("FAIL %s: done never rose (actual 0 expected 1)", req);
        end else begin
            check(req, addr, exp);
            // R9: address valid the cycle before done
            check("R9 addr before done", prev, addr);
            @(negedge clk);
            check("R9 done pulse width", {15'd0, done}, 16'd0);
            check("R9 addr hold", addr, exp);
        end
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r [8];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset addr", addr, 16'h0000);
        check("R1 reset done", {15'd0, done}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle done", {15'd0, done}, 16'd0);

        // R2: unit subscripts give the base
        run(16'h1234, 16'd1, 16'd1, 16'd1, 16'd10, 16'd7, 16'd3, 16'h0000, "R2 2d unit", 1'b0);
        run(16'h4321, 16'd1, 16'd1, 16'd1, 16'd10, 16'd7, 16'd3, 16'h0001, "R2 3d unit", 1'b0);
        // R3
        run(16'h0100, 16'd3, 16'd4, 16'd9, 16'd10, 16'd20, 16'd1, 16'h0000, "R3 2d basic", 1'b0);
        run(16'h0100, 16'd3, 16'd4, 16'hBEEF, 16'd10, 16'hCAFE, 16'd1, 16'h0000, "R3 2d ignores k/D2", 1'b0);
        // R4
        run(16'h0200, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd2, 16'h0001, "R4 3d basic", 1'b0);
        // R5: upper selector bits ignored
        run(16'h0300, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd2, 16'hFFFE, "R5 upper bits 2d", 1'b0);
        run(16'h0300, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd2, 16'h8001, "R5 upper bits 3d", 1'b0);
        // R6: large values wrap modulo 2^16
        run(16'hF000, 16'h7FFF, 16'h1234, 16'h0F0F, 16'h0ABC, 16'h0DEF, 16'd4, 16'h0001, "R6 wrap", 1'b0);
        // R7: zero and negative subscripts
        run(16'h0500, 16'd0, 16'd0, 16'd0, 16'd8, 16'd8, 16'd2, 16'h0001, "R7 zero subs", 1'b0);
        run(16'h0500, 16'hFFFF, 16'hFFFE, 16'd1, 16'd8, 16'd8, 16'd2, 16'h0000, "R7 negative subs", 1'b0);
        // R10: second start mid-run ignored
        run(16'h0600, 16'd5, 16'd6, 16'd7, 16'd11, 16'd13, 16'd3, 16'h0001, "R10 busy start", 1'b1);

        for (int n = 0; n < 40; n++) begin
            for (int q = 0; q < 8; q++) r[q] = 16'($urandom);
            if (n % 2 == 0) begin
                r[1] = r[1] & 16'h003F; r[2] = r[2] & 16'h003F; r[3] = r[3] & 16'h003F;
                r[4] = r[4] & 16'h00FF; r[5] = r[5] & 16'h00FF; r[6] = r[6] & 16'h000F;
            end
            run(r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7],
                r[7][0] ? "R4 R6 random 3d" : "R3 R6 random 2d", 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule